// File: doc/BRIEF.md
# High-Word Signed Multiply-Accumulate with Optional Rounding

This unit multiplies two signed 32-bit operands and returns only the upper 32 bits of a 64-bit intermediate value. The intermediate can be the bare product. It can also be the product added to, or taken away from, a signed accumulator word that sits in the upper half of a 64-bit value whose lower half is zero. Selecting rounding adds half of one least significant bit of the upper word (the constant 0x80000000) to the intermediate before the upper word is taken. Without rounding, the result is the arithmetic floor of the intermediate divided by 2^32.

An operation is started by raising `op_valid` together with the operands, the operation code and the rounding bit. After a single register stage the result is presented with `res_valid`. The unit accepts a new operation on every cycle and has no flags or status outputs.

Top module: `hiword_mac`

## Requirements
- R1: With `op_kind` = 2'b00 (product only), `res_word` equals bits 63:32 of the signed 64-bit product of `op_a` and `op_b`.
- R2: With `op_kind` = 2'b01 (accumulate add), `res_word` equals bits 63:32 of ({`op_acc`, 32'h0} + a*b), computed modulo 2^64.
- R3: With `op_kind` = 2'b10 (accumulate subtract), `res_word` equals bits 63:32 of ({`op_acc`, 32'h0} - a*b), computed modulo 2^64.
- R4: When `op_round` is 1, 64'h0000_0000_8000_0000 is added to the intermediate before bits 63:32 are taken. When it is 0, the low word is simply dropped, which rounds toward negative infinity.
- R5: `op_kind` = 2'b11 behaves exactly like 2'b00.
- R6: The result and `res_valid` appear exactly one clock after the `op_valid` cycle. `res_valid` is 0 in every cycle whose previous cycle had `op_valid` = 0.
- R7: While `res_valid` is 0, `res_word` keeps its last value. Inputs presented with `op_valid` = 0 have no effect on it.
- R8: After reset, `res_valid` = 0 and `res_word` = 0.
- R9: All arithmetic wraps modulo 2^64. For example, (-2^31)*(-2^31) with accumulator 0x7FFFFFFF in add mode gives 0xBFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_a | input | 32 | Signed multiplicand |
| op_b | input | 32 | Signed multiplier |
| op_acc | input | 32 | Accumulator word, aligned to bits 63:32 |
| op_kind | input | 2 | 00 product, 01 add, 10 subtract, 11 product |
| op_round | input | 1 | Add 0x80000000 before taking the upper word |
| res_valid | output | 1 | Result strobe |
| res_word | output | 32 | Upper word of the intermediate |

## Verification
Because the only state is the output register, an internal error appears on the ports in the cycle right after the operation that caused it. A wrong mode decode or sign extension changes `res_word` on the next strobe. An off-by-one in the rounding constant or in the subtraction usually affects only the lowest result bits, so the stimulus includes low words near 0x80000000 and the extreme operands. An error in strobe timing shows up as `res_valid` arriving in the wrong cycle.

// File: rtl/hiword_mac_pkg.sv
package hiword_mac_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned WIDE_W = 2 * WORD_W;

    typedef enum logic [1:0] {
        KIND_MUL  = 2'b00,
        KIND_ADD  = 2'b01,
        KIND_SUB  = 2'b10,
        KIND_MUL2 = 2'b11
    } kind_e;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } out_state_t;
endpackage

// File: rtl/hiword_mac_mult.sv
module hiword_mac_mult #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o
);
    logic signed [2*W-1:0] a_ext;
    logic signed [2*W-1:0] b_ext;

    always_comb begin
        a_ext  = {{W{a_i[W-1]}}, a_i};
        b_ext  = {{W{b_i[W-1]}}, b_i};
        prod_o = a_ext * b_ext;
    end
endmodule

// File: rtl/hiword_mac_combine.sv
module hiword_mac_combine #(
    parameter int unsigned W = 32
) (
    input  logic [2*W-1:0] prod_i,
    input  logic [W-1:0]   acc_i,
    input  logic           use_acc_i,
    input  logic           negate_i,
    input  logic           round_i,
    output logic [W-1:0]   high_o
);
    localparam logic [2*W-1:0] HALF_LSB = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

    logic [2*W-1:0] base;
    logic [2*W-1:0] term;
    logic [2*W-1:0] sum;

    always_comb begin
        base   = use_acc_i ? {acc_i, {W{1'b0}}} : '0;
        term   = negate_i ? (~prod_i + 1'b1) : prod_i;
        sum    = base + term + (round_i ? HALF_LSB : '0);
        high_o = sum[2*W-1:W];
    end
endmodule

// File: rtl/hiword_mac.sv
module hiword_mac
    import hiword_mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] op_acc,
    input  logic [1:0]        op_kind,
    input  logic              op_round,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_word
);
    logic [WIDE_W-1:0] prod;
    logic [WORD_W-1:0] high;
    logic              use_acc;
    logic              negate;
    out_state_t        st_d, st_q;

    always_comb begin
        use_acc = (op_kind == KIND_ADD) || (op_kind == KIND_SUB);
        negate  = (op_kind == KIND_SUB);
    end

    hiword_mac_mult #(.W(WORD_W)) u_mult (
        .a_i   (op_a),
        .b_i   (op_b),
        .prod_o(prod)
    );

    hiword_mac_combine #(.W(WORD_W)) u_comb (
        .prod_i   (prod),
        .acc_i    (op_acc),
        .use_acc_i(use_acc),
        .negate_i (negate),
        .round_i  (op_round),
        .high_o   (high)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = op_valid;
        if (op_valid) st_d.word = high;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.vld;
    assign res_word  = st_q.word;
endmodule

// File: rtl/hiword_mac_checks.sv
module hiword_mac_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic [1:0]  op_kind,
    input logic        op_round,
    input logic        res_valid,
    input logic [31:0] res_word
);
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (res_valid == $past(op_valid)));

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(op_valid)) |-> $stable(res_word));

    a_r1_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_kind == 2'b00 || op_kind == 2'b11) && !op_round && (op_a == 32'h0 || op_b == 32'h0))
        |=> (res_word == 32'h0));

    a_r4_round_zero_product: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b00 && op_round && op_a == 32'h0) |=> (res_word == 32'h0));

    a_r8_reset_state: assert property (@(posedge clk)
        !rst_n |-> (!res_valid && res_word == 32'h0));
endmodule

bind hiword_mac hiword_mac_checks u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .op_kind  (op_kind),
    .op_round (op_round),
    .res_valid(res_valid),
    .res_word (res_word)
);

// File: tb/hiword_mac_test.sv
module hiword_mac_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_acc = '0;
    logic [1:0]  op_kind = '0;
    logic        op_round = 1'b0;
    logic        res_valid;
    logic [31:0] res_word;

    int tests = 0;
    int fails = 0;
    logic [31:0] last_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hiword_mac uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
        .op_acc(op_acc), .op_kind(op_kind), .op_round(op_round),
        .res_valid(res_valid), .res_word(res_word)
    );

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] acc, input logic [1:0] k,
                                          input logic rnd);
        longint p, v;
        p = longint'($signed(a)) * longint'($signed(b));
        case (k)
            2'b01:   v = {acc, 32'h0} + p;
            2'b10:   v = {acc, 32'h0} - p;
            default: v = p;
        endcase
        if (rnd) v = v + 64'h8000_0000;
        return v[63:32];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one op, check one cycle later at the falling edge.
    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] acc, input logic [1:0] k, input logic rnd);
        logic [31:0] exp;
        exp = model(a, b, acc, k, rnd);
        @(negedge clk);
        op_valid = 1'b1; op_a = a; op_b = b; op_acc = acc; op_kind = k; op_round = rnd;
        @(negedge clk);
        op_valid = 1'b0;
        check({req, " valid"}, {31'h0, res_valid}, 32'h1);
        check(req, res_word, exp);
        last_word = exp;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        check("R8 reset valid", {31'h0, res_valid}, 32'h0);
        check("R8 reset word", res_word, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 directed
        run_op("R1 mul pos", 32'h0001_0000, 32'h0003_0000, 0, 2'b00, 0);
        run_op("R1 mul neg floor", 32'hFFFF_FFFF, 32'h0000_0001, 0, 2'b00, 0);
        // R2
        run_op("R2 add", 32'h0002_0000, 32'h0000_8000, 32'h0000_0010, 2'b01, 0);
        // R3
        run_op("R3 sub", 32'h0002_0000, 32'h0000_8000, 32'h0000_0010, 2'b10, 0);
        run_op("R3 sub low borrow", 32'h0000_0001, 32'h0000_0001, 32'h5, 2'b10, 0);
        // R4 rounding boundary: low word exactly 0x80000000 and just below
        run_op("R4 round half up", 32'h0000_8000, 32'h0001_0000, 0, 2'b00, 1);
        check("R4 round half value", last_word, 32'h1);
        run_op("R4 round below half", 32'h0000_7FFF, 32'h0001_0000, 0, 2'b00, 1);
        check("R4 round below value", last_word, 32'h0);
        run_op("R4 round sub", 32'h0000_0001, 32'h8000_0000, 32'h0, 2'b10, 1);
        // R5
        run_op("R5 kind 11", 32'h1234_5678, 32'h8765_4321, 32'hDEAD_BEEF, 2'b11, 0);
        // R9 extreme
        run_op("R9 wrap", 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 2'b01, 0);
        check("R9 wrap value", last_word, 32'hBFFF_FFFF);
        run_op("R9 wrap sub", 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 2'b10, 1);

        // R6/R7: idle cycles with changing inputs
        @(negedge clk);
        op_a = 32'h7FFF_FFFF; op_b = 32'h7FFF_FFFF; op_kind = 2'b01; op_acc = 32'h1;
        @(negedge clk);
        check("R6 idle valid low", {31'h0, res_valid}, 32'h0);
        check("R7 idle hold", res_word, last_word);
        @(negedge clk);
        check("R7 idle hold 2", res_word, last_word);

        // Back-to-back stream (R6), random (R1..R4)
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'h5EED);
            for (int i = 0; i < 400; i++) begin
                logic [31:0] a, b, c, e;
                logic [1:0] k;
                logic r;
                a = $urandom; b = $urandom; c = $urandom;
                k = 2'($urandom); r = 1'($urandom);
                if (i % 17 == 0) a = 32'h8000_0000;
                if (i % 19 == 0) b = 32'h7FFF_FFFF;
                e = model(a, b, c, k, r);
                @(negedge clk);
                op_valid = 1'b1; op_a = a; op_b = b; op_acc = c; op_kind = k; op_round = r;
                @(negedge clk);
                check("R6 stream valid", {31'h0, res_valid}, 32'h1);
                check("R1-R4 random", res_word, e);
            end
            @(negedge clk);
            op_valid = 1'b0;
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule